// File: doc/BRIEF.md
# Register Renamer with Physical Tag Pool

This block gives every register named by an instruction a physical tag taken from a pool that is larger than the architectural register set. Each accepted instruction brings one destination and three source register numbers. The sources are translated through a map table that holds the current physical tag of each architectural register. The destination is given a fresh tag taken from the head of a free-tag FIFO, and the map table is pointed at that new tag. The tag that the destination held before is not freed at once. It waits in a return queue until a completion pulse says that the oldest renamed instruction has finished, and only then does it go to the back of the free FIFO.

A small controller follows the pool with two named states. In `ST_AVAIL` the free FIFO holds at least one tag. In `ST_DRAINED` the free FIFO is empty and renaming stalls. The transition `AVAIL->DRAINED` is taken when an accepted rename uses the last free tag and no completion refills the FIFO in the same cycle. The transition `DRAINED->AVAIL` is taken on a completion while the return queue holds an entry. The renamed fields appear in registers one cycle after the rename is accepted.

Top module: `rn_rename_top`

## Requirements
- R1: After reset, `stall_o` and `rn_valid_o` are 0, and the map table sends each architectural register i to physical tag i.
- R2: After reset, the free FIFO holds tags 32 to 39, and successive renames with no completion receive them in ascending order.
- R3: A rename is accepted when `ren_valid_i` is 1 and `stall_o` is 0. In the next cycle `rn_valid_o` is 1 for that cycle only. Source k is taken from `ren_src_i[5k+4:5k]` and its tag appears on `rn_src_o[6k+5:6k]`.
- R4: The destination tag on `rn_dst_o` is the head of the free FIFO. Later instructions that read the same architectural register get that tag.
- R5: When an instruction uses its own destination register as a source, that source gets the mapping held before the instruction.
- R6: The replaced tag of each destination enters the return queue. Each `cmpl_i` pulse moves the oldest entry to the back of the free FIFO, so it is allocated after the tags already waiting there.
- R7: `stall_o` is 1 while the free FIFO is empty or the return queue holds 32 entries. A rename request made while stalled produces no output and changes neither the map nor the pool.
- R8: A `cmpl_i` pulse while the return queue is empty has no effect.
- R9: A rename and a completion in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid_i | input | 1 | Rename request |
| ren_dst_i | input | 5 | Architectural destination register |
| ren_src_i | input | 15 | Three architectural sources, 5 bits each, source 0 in the lowest bits |
| cmpl_i | input | 1 | Oldest renamed instruction has completed |
| stall_o | output | 1 | Renaming cannot accept a request |
| rn_valid_o | output | 1 | Renamed fields are valid |
| rn_dst_o | output | 6 | New physical destination tag |
| rn_src_o | output | 18 | Three physical source tags, 6 bits each, source 0 in the lowest bits |

## Verification
The renamed fields come out of one output register, so they are due at the first rising edge after an accepted request. The bench drives each request at a falling edge and compares the fields at the next falling edge. `stall_o` is decoded from the current state with no register in its path, so the bench compares it at the falling edge just before each request is driven, against a pool model built from R2, R6 and R8. Completions change the free FIFO at the same edge as a rename. A freed tag therefore becomes available to the request that follows that edge, and the model applies the allocation before the return, in that order.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int ARCH_REGS = 32;
    localparam int PHYS_REGS = 40;
    localparam int SRC_CNT   = 3;
    localparam int PRQ_DEPTH = 32;

    typedef enum logic [0:0] {
        ST_AVAIL   = 1'b0,
        ST_DRAINED = 1'b1
    } rn_state_e;
endpackage

// File: rtl/rn_tag_fifo.sv
module rn_tag_fifo #(
    parameter int DEPTH     = 8,
    parameter int W         = 6,
    parameter int INIT_CNT  = 0,
    parameter int INIT_BASE = 0,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  push_data_i,
    input  logic          pop_i,
    output logic [W-1:0]  head_o,
    output logic [CW-1:0] count_o
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic          is_empty;
    logic          is_full;
    logic          do_pop;
    logic          do_push;

    assign is_empty = (count_o == '0);
    assign is_full  = (count_o == CW'(DEPTH));
    assign do_pop   = pop_i && !is_empty;
    assign do_push  = push_i && (!is_full || do_pop);
    assign head_o   = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i < INIT_CNT) ? W'(INIT_BASE + i) : '0;
            end
            rd_ptr  <= '0;
            wr_ptr  <= PW'(INIT_CNT % DEPTH);
            count_o <= CW'(INIT_CNT);
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_data_i;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (do_push && !do_pop) begin
                count_o <= count_o + CW'(1);
            end else if (do_pop && !do_push) begin
                count_o <= count_o - CW'(1);
            end
        end
    end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int AREGS = 32,
    parameter int TW    = 6,
    parameter int NRD   = 4,
    localparam int AW = $clog2(AREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NRD*AW-1:0] rd_idx_i,
    output logic [NRD*TW-1:0] rd_tag_o,
    input  logic              we_i,
    input  logic [AW-1:0]     wr_idx_i,
    input  logic [TW-1:0]     wr_tag_i
);
    logic [TW-1:0] map_q [AREGS];

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_tag_o[g*TW +: TW] = map_q[rd_idx_i[g*AW +: AW]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < AREGS; i++) begin
                map_q[i] <= TW'(i);
            end
        end else if (we_i) begin
            map_q[wr_idx_i] <= wr_tag_i;
        end
    end
endmodule

// File: rtl/rn_ctrl_fsm.sv
module rn_ctrl_fsm
    import rn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ren_valid_i,
    input  logic cmpl_i,
    input  logic fl_last_i,
    input  logic prq_nonempty_i,
    input  logic prq_full_i,
    output logic stall_o,
    output logic accept_o,
    output logic retire_o
);
    rn_state_e state_q;
    rn_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_AVAIL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        stall_o  = (state_q == ST_DRAINED) || prq_full_i;
        accept_o = ren_valid_i && !stall_o;
        retire_o = cmpl_i && prq_nonempty_i;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AVAIL: begin
                if (accept_o && fl_last_i && !retire_o) begin
                    state_d = ST_DRAINED;
                end
            end
            ST_DRAINED: begin
                if (retire_o) begin
                    state_d = ST_AVAIL;
                end
            end
            default: state_d = ST_AVAIL;
        endcase
    end
endmodule

// File: rtl/rn_rename_top.sv
module rn_rename_top
    import rn_pkg::*;
#(
    parameter int NARCH = ARCH_REGS,
    parameter int NPHYS = PHYS_REGS,
    parameter int NSRC  = SRC_CNT,
    parameter int QDEP  = PRQ_DEPTH,
    localparam int AW     = $clog2(NARCH),
    localparam int TW     = $clog2(NPHYS),
    localparam int FL_DEP = NPHYS - NARCH,
    localparam int FL_CW  = $clog2(FL_DEP + 1),
    localparam int Q_CW   = $clog2(QDEP + 1),
    localparam int NRD    = NSRC + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ren_valid_i,
    input  logic [AW-1:0]    ren_dst_i,
    input  logic [NSRC*AW-1:0] ren_src_i,
    input  logic             cmpl_i,
    output logic             stall_o,
    output logic             rn_valid_o,
    output logic [TW-1:0]    rn_dst_o,
    output logic [NSRC*TW-1:0] rn_src_o
);
    logic [NRD*AW-1:0] rd_idx;
    logic [NRD*TW-1:0] rd_tag;
    logic [TW-1:0]     fl_head;
    logic [FL_CW-1:0]  fl_count;
    logic [TW-1:0]     prq_head;
    logic [Q_CW-1:0]   prq_count;
    logic              accept;
    logic              retire;

    assign rd_idx = {ren_dst_i, ren_src_i};

    rn_map_table #(.AREGS(NARCH), .TW(TW), .NRD(NRD)) map_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_i (rd_idx),
        .rd_tag_o (rd_tag),
        .we_i     (accept),
        .wr_idx_i (ren_dst_i),
        .wr_tag_i (fl_head)
    );

    rn_tag_fifo #(.DEPTH(FL_DEP), .W(TW), .INIT_CNT(FL_DEP), .INIT_BASE(NARCH)) free_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (retire),
        .push_data_i (prq_head),
        .pop_i       (accept),
        .head_o      (fl_head),
        .count_o     (fl_count)
    );

    rn_tag_fifo #(.DEPTH(QDEP), .W(TW), .INIT_CNT(0), .INIT_BASE(0)) prq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (accept),
        .push_data_i (rd_tag[NSRC*TW +: TW]),
        .pop_i       (retire),
        .head_o      (prq_head),
        .count_o     (prq_count)
    );

    rn_ctrl_fsm ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .ren_valid_i    (ren_valid_i),
        .cmpl_i         (cmpl_i),
        .fl_last_i      (fl_count == FL_CW'(1)),
        .prq_nonempty_i (prq_count != '0),
        .prq_full_i     (prq_count == Q_CW'(QDEP)),
        .stall_o        (stall_o),
        .accept_o       (accept),
        .retire_o       (retire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rn_valid_o <= 1'b0;
            rn_dst_o   <= '0;
            rn_src_o   <= '0;
        end else begin
            rn_valid_o <= accept;
            if (accept) begin
                rn_dst_o <= fl_head;
                rn_src_o <= rd_tag[NSRC*TW-1:0];
            end
        end
    end
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
    parameter int NPHYS = 40,
    parameter int NARCH = 32,
    parameter int TW    = 6,
    parameter int FL_CW = 4,
    parameter int Q_CW  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ren_valid_i,
    input logic             cmpl_i,
    input logic             stall_o,
    input logic             rn_valid_o,
    input logic [TW-1:0]    rn_dst_o,
    input logic [FL_CW-1:0] fl_count,
    input logic [Q_CW-1:0]  prq_count
);
    assert_accept_gives_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid_i && !stall_o) |=> rn_valid_o);

    assert_no_out_without_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ren_valid_i && !stall_o) |=> !rn_valid_o);

    assert_empty_pool_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_count == '0) |-> stall_o);

    assert_tags_conserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fl_count) + int'(prq_count)) == (NPHYS - NARCH));

    assert_dst_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rn_valid_o |-> (int'(rn_dst_o) < NPHYS));

    assert_idle_cmpl_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_i && prq_count == '0 && !(ren_valid_i && !stall_o)) |=> $stable(fl_count));
endmodule

bind rn_rename_top rn_rename_chk #(
    .NPHYS(NPHYS), .NARCH(NARCH), .TW(TW), .FL_CW(FL_CW), .Q_CW(Q_CW)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ren_valid_i (ren_valid_i),
    .cmpl_i      (cmpl_i),
    .stall_o     (stall_o),
    .rn_valid_o  (rn_valid_o),
    .rn_dst_o    (rn_dst_o),
    .fl_count    (fl_count),
    .prq_count   (prq_count)
);

// File: tb/rn_rename_top_tb_top.sv
`timescale 1ns/1ps
module rn_rename_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ren_valid_i = 1'b0;
    logic [4:0]  ren_dst_i = '0;
    logic [14:0] ren_src_i = '0;
    logic        cmpl_i = 1'b0;
    logic        stall_o;
    logic        rn_valid_o;
    logic [5:0]  rn_dst_o;
    logic [17:0] rn_src_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int exp_map [32];
    int free_q [$];
    int prq_q [$];

    always #2.5 clk = ~clk;

    rn_rename_top dut_i (
        .clk(clk), .rst_n(rst_n), .ren_valid_i(ren_valid_i), .ren_dst_i(ren_dst_i),
        .ren_src_i(ren_src_i), .cmpl_i(cmpl_i), .stall_o(stall_o),
        .rn_valid_o(rn_valid_o), .rn_dst_o(rn_dst_o), .rn_src_o(rn_src_o)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit model_stall();
        return (free_q.size() == 0) || (prq_q.size() == 32);
    endfunction

    // Called at a falling edge; applies one cycle and checks at the next falling edge.
    task automatic step(bit rv, int d, int s0, int s1, int s2, bit cm, string req);
        bit acc;
        bit ret;
        int e_src [3];
        int e_dst;
        int ret_tag;
        check(req, "stall_o", int'(stall_o), int'(model_stall()));
        acc = rv && !model_stall();
        ret = cm && (prq_q.size() > 0);
        ren_valid_i = rv;
        ren_dst_i   = 5'(d);
        ren_src_i   = {5'(s2), 5'(s1), 5'(s0)};
        cmpl_i      = cm;
        e_dst = 0;
        ret_tag = 0;
        e_src[0] = exp_map[s0];
        e_src[1] = exp_map[s1];
        e_src[2] = exp_map[s2];
        if (ret) ret_tag = prq_q.pop_front();
        if (acc) begin
            e_dst = free_q.pop_front();
            prq_q.push_back(exp_map[d]);
            exp_map[d] = e_dst;
        end
        if (ret) free_q.push_back(ret_tag);
        @(posedge clk);
        @(negedge clk);
        ren_valid_i = 1'b0;
        cmpl_i      = 1'b0;
        check(req, "rn_valid_o", int'(rn_valid_o), int'(acc));
        if (acc) begin
            check(req, "rn_dst_o", int'(rn_dst_o), e_dst);
            for (int k = 0; k < 3; k++) begin
                check(req, "rn_src_o", int'(rn_src_o[k*6 +: 6]), e_src[k]);
            end
        end
    endtask

    task automatic t_reset_state();
        check("R1", "stall_o after reset", int'(stall_o), 0);
        check("R1", "rn_valid_o after reset", int'(rn_valid_o), 0);
    endtask

    task automatic t_identity();
        step(1, 1, 0, 5, 31, 0, "R1");
        check("R2", "first tag", int'(rn_dst_o), 32);
        check("R1", "src2 identity", int'(rn_src_o[17:12]), 31);
        step(0, 0, 0, 0, 0, 0, "R3");
    endtask

    task automatic t_self_read();
        step(1, 1, 1, 1, 2, 0, "R5");
        check("R5", "self source old tag", int'(rn_src_o[5:0]), 32);
        step(1, 3, 1, 9, 3, 0, "R4");
        check("R4", "later reader sees new tag", int'(rn_src_o[5:0]), 33);
    endtask

    task automatic t_drain();
        for (int i = 0; i < 5; i++) begin
            step(1, 10 + i, 10 + i, 1, 3, 0, "R2");
        end
        check("R2", "last pool tag", int'(rn_dst_o), 39);
        step(1, 7, 7, 7, 7, 0, "R7");
        check("R7", "stall when pool empty", int'(stall_o), 1);
    endtask

    task automatic t_return();
        step(0, 0, 0, 0, 0, 1, "R6");
        step(1, 4, 7, 1, 0, 0, "R6");
        check("R6", "returned oldest tag", int'(rn_dst_o), 1);
        check("R7", "stalled request left map", int'(rn_src_o[5:0]), 7);
    endtask

    task automatic t_cmpl_empty();
        for (int i = 0; i < 8; i++) begin
            step(0, 0, 0, 0, 0, 1, "R6");
        end
        step(0, 0, 0, 0, 0, 1, "R8");
        for (int i = 0; i < 8; i++) begin
            step(1, 20 + i, 20 + i, 4, 1, 0, "R8");
        end
        check("R8", "stall after 8 renames", int'(stall_o), 1);
    endtask

    task automatic t_simul();
        step(0, 0, 0, 0, 0, 1, "R9");
        for (int i = 0; i < 6; i++) begin
            step(1, 28 + (i % 3), 28, 20, 21, 1, "R9");
        end
        check("R9", "pool unchanged by paired ops", int'(stall_o), 0);
        step(1, 2, 2, 28, 29, 0, "R9");
        check("R9", "stall after last tag", int'(stall_o), 1);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) exp_map[i] = i;
        for (int i = 32; i < 40; i++) free_q.push_back(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_identity();
        t_self_read();
        t_drain();
        t_return();
        t_cmpl_empty();
        t_simul();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule